// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the arithmetic and logic core of a small accumulator machine. It holds an 8-bit accumulator and a five-flag status register. The second operand arrives on a temporary-register input. A 3-bit operation select chooses one of eight operations: add, add with carry, subtract, subtract with borrow, AND, OR, XOR and compare.

On each clock edge where the load strobe is high, the result is written back to the accumulator and the flags are updated from that result. Compare is the exception: it updates the flags and leaves the accumulator as it was. The carry-in for the carry and borrow variants is the stored carry flag.

The accumulator starts at zero after reset. Any start value can therefore be placed in it by an OR with the wanted value. The flags leave the block as one packed status byte with a fixed bit layout.

Top module: `flag_alu8`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to 0x00 and all five stored flags. After reset `flags_o` reads 0x02.
- R2: On a clock edge where `load_i` is low, `acc_o` and `flags_o` keep their values whatever `op_i` and `tmp_i` carry.
- R3: Op 0 (ADD) loads A+T and op 1 (ADC) loads A+T+CY, both modulo 256. CY becomes the carry out of bit 7.
- R4: Op 2 (SUB) loads A−T and op 3 (SBB) loads A−T−CY, both modulo 256. CY becomes 1 exactly when the subtraction borrows, that is when A < T (+CY).
- R5: For ADD and ADC, AC is the carry out of bit 3 of the sum. For SUB, SBB and compare, AC is 1 exactly when the low nibbles borrow: A[3:0] < T[3:0] (+CY).
- R6: Op 4 (AND), op 5 (OR) and op 6 (XOR) load the bitwise result and clear CY. AC is set by AND and cleared by OR and XOR.
- R7: S is bit 7 of the result, Z is 1 when the 8-bit result is zero, and P is 1 when the result holds an even number of ones.
- R8: Op 7 (compare) sets all flags exactly as SUB would for the same operands and leaves the accumulator unchanged.
- R9: The status byte is {S, Z, 0, AC, 0, P, 1, CY}, with S in bit 7 and CY in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmp_i | input | 8 | Second operand (temporary register) |
| op_i | input | 3 | Operation select, encoded as in R3, R4, R6 and R8 |
| load_i | input | 1 | Update strobe for accumulator and flags |
| acc_o | output | 8 | Accumulator value |
| flags_o | output | 8 | Packed status byte |

## Verification
The assertions check the following on every cycle:
- the accumulator and flags stay put without a strobe;
- compare never alters the accumulator;
- a plain add yields the 9-bit sum of the previous accumulator and operand;
- logical operations clear carry;
- sign, zero and parity match the newly loaded accumulator.

The borrow sense of CY and AC under subtract and SBB, the nibble carry, the chaining of the stored carry into ADC and SBB, and the flag results of compare can only be shown by the bench's scenarios. The bench runs a reference model across mixed operation sequences and adds directed cases with hand-derived values, including wraparound to zero and a borrow out of 0x00.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    function automatic logic even_ones(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction

    function automatic logic [7:0] pack_flags(input flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         use_cin,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         ac
);
    logic [W-1:0]  b_eff;
    logic          c0;
    logic [NW:0]   lo_sum;
    logic [W:0]    full_sum;

    always_comb begin
        b_eff    = sub ? ~b : b;
        c0       = (use_cin & cin) ^ sub;
        lo_sum   = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c0};
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        res      = full_sum[W-1:0];
        cy       = full_sum[W] ^ sub;
        ac       = lo_sum[NW] ^ sub;
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  alu8_pkg::alu_op_e op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      res,
    output logic              ac
);
    import alu8_pkg::*;

    always_comb begin
        unique case (op)
            OP_AND:  begin res = a & b; ac = 1'b1; end
            OP_OR:   begin res = a | b; ac = 1'b0; end
            default: begin res = a ^ b; ac = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
    parameter int W = 8
) (
    input  logic [W-1:0]     res,
    input  logic             cy,
    input  logic             ac,
    output alu8_pkg::flags_t flags
);
    import alu8_pkg::*;

    always_comb begin
        flags.s  = res[W-1];
        flags.z  = (res == '0);
        flags.ac = ac;
        flags.p  = even_ones(res);
        flags.cy = cy;
    end
endmodule

// File: rtl/flag_alu8.sv
module flag_alu8 (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] tmp_i,
    input  logic [2:0] op_i,
    input  logic       load_i,
    output logic [7:0] acc_o,
    output logic [7:0] flags_o
);
    import alu8_pkg::*;

    localparam int W  = DATA_W;
    localparam int NW = NIB_W;

    alu_op_e      op;
    logic         is_sub, use_cin, is_logic;
    logic [W-1:0] acc_q;
    flags_t       flag_q, flag_d;
    logic [W-1:0] ar_res, lg_res, res_mux;
    logic         ar_cy, ar_ac, lg_ac, cy_mux, ac_mux;

    assign op       = alu_op_e'(op_i);
    assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    assign use_cin  = (op == OP_ADC) || (op == OP_SBB);
    assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);

    alu8_addsub #(.W(W), .NW(NW)) u_addsub (
        .a       (acc_q),
        .b       (tmp_i),
        .sub     (is_sub),
        .use_cin (use_cin),
        .cin     (flag_q.cy),
        .res     (ar_res),
        .cy      (ar_cy),
        .ac      (ar_ac)
    );

    alu8_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (acc_q),
        .b   (tmp_i),
        .res (lg_res),
        .ac  (lg_ac)
    );

    always_comb begin
        res_mux = is_logic ? lg_res : ar_res;
        cy_mux  = is_logic ? 1'b0   : ar_cy;
        ac_mux  = is_logic ? lg_ac  : ar_ac;
    end

    alu8_status #(.W(W)) u_status (
        .res   (res_mux),
        .cy    (cy_mux),
        .ac    (ac_mux),
        .flags (flag_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            flag_q <= '0;
        end else if (load_i) begin
            flag_q <= flag_d;
            if (op != OP_CMP) acc_q <= res_mux;
        end
    end

    assign acc_o   = acc_q;
    assign flags_o = pack_flags(flag_q);

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(acc_o) && $stable(flags_o))); // R2

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i == 3'd7) |=> $stable(acc_o)); // R8

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i == 3'd0) |=>
        ({flags_o[0], acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(tmp_i)}))); // R3

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i >= 3'd4 && op_i != 3'd7) |=> (flags_o[0] == 1'b0)); // R6

    AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i != 3'd7) |=>
        (flags_o[7] == acc_o[7] && flags_o[6] == (acc_o == 8'h00) &&
         flags_o[2] == ~^acc_o)); // R7
endmodule

// File: tb/sim_flag_alu8.sv
module sim_flag_alu8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tmp_r = 8'h00;
    logic [2:0] op_r = 3'd0;
    logic       load_r = 1'b0;
    logic [7:0] acc_o, flags_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [7:0] m_acc;
    logic       m_cy;

    always #4 clk = ~clk;

    flag_alu8 u0 (
        .clk(clk), .rst(rst), .tmp_i(tmp_r), .op_i(op_r),
        .load_i(load_r), .acc_o(acc_o), .flags_o(flags_o)
    );

    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 8'h88}, {3'd1, 8'h79}, {3'd2, 8'h40}, {3'd3, 8'h01},
        {3'd6, 8'hFF}, {3'd5, 8'h80}, {3'd7, 8'h80}, {3'd4, 8'hF0},
        {3'd2, 8'hFF}, {3'd1, 8'h00}, {3'd7, 8'h00}, {3'd3, 8'h7F},
        {3'd6, 8'h5A}, {3'd0, 8'h00}, {3'd5, 8'h00}, {3'd4, 8'h00}
    };

    function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] t, input logic c);
        int s, lo, ones;
        logic [7:0] r;
        logic cyo, aco, cin;
        cin = (op == 3'd1 || op == 3'd3) ? c : 1'b0;
        s = 0; lo = 0; r = 8'h00; cyo = 1'b0; aco = 1'b0;
        case (op)
            3'd0, 3'd1: begin
                s   = int'(a) + int'(t) + int'(cin);
                lo  = int'(a[3:0]) + int'(t[3:0]) + int'(cin);
                r   = s[7:0];
                cyo = (s > 255);
                aco = (lo > 15);
            end
            3'd2, 3'd3, 3'd7: begin
                s   = int'(a) - int'(t) - int'(cin);
                lo  = int'(a[3:0]) - int'(t[3:0]) - int'(cin);
                r   = s[7:0];
                cyo = (s < 0);
                aco = (lo < 0);
            end
            3'd4: begin r = a & t; aco = 1'b1; end
            3'd5: r = a | t;
            default: r = a ^ t;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        return {(op == 3'd7) ? a : r,
                r[7], (r == 8'h00), 1'b0, aco, 1'b0, ((ones % 2) == 0), 1'b1, cyo};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        if (op < 3'd2) return "R3/R5/R7/R9";
        if (op < 3'd4) return "R4/R5/R7/R9";
        if (op < 3'd7) return "R6/R7/R9";
        return "R8/R5/R9";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [7:0] t, input logic ld);
        @(negedge clk);
        op_r = op; tmp_r = t; load_r = ld;
        @(negedge clk);
        load_r = 1'b0;
    endtask

    task automatic run_model(input logic [2:0] op, input logic [7:0] t);
        logic [15:0] e;
        e = model(op, m_acc, t, m_cy);
        step(op, t, 1'b1);
        check(req_of(op), "acc", acc_o, e[15:8]);
        check(req_of(op), "flags", flags_o, e[7:0]);
        m_acc = e[15:8];
        m_cy  = e[0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "reset acc", acc_o, 8'h00);
        check("R1", "reset flags", flags_o, 8'h02);

        step(3'd0, 8'hFF, 1'b1);
        check("R3", "add acc", acc_o, 8'hFF);
        check("R7", "add flags", flags_o, 8'h86);
        step(3'd0, 8'h01, 1'b1);
        check("R3", "wrap acc", acc_o, 8'h00);
        check("R5", "wrap flags", flags_o, 8'h57);
        step(3'd3, 8'h00, 1'b1);
        check("R4", "sbb acc", acc_o, 8'hFF);
        check("R4", "sbb flags", flags_o, 8'h97);
        step(3'd7, 8'hFF, 1'b1);
        check("R8", "cmp acc", acc_o, 8'hFF);
        check("R8", "cmp flags", flags_o, 8'h46);
        step(3'd0, 8'h55, 1'b0);
        check("R2", "hold acc", acc_o, 8'hFF);
        check("R2", "hold flags", flags_o, 8'h46);
        step(3'd4, 8'h0F, 1'b1);
        check("R6", "and acc", acc_o, 8'h0F);
        check("R6", "and flags", flags_o, 8'h16);

        m_acc = 8'h0F;
        m_cy  = 1'b0;
        for (int k = 0; k < NV; k++) run_model(VEC[k][10:8], VEC[k][7:0]);

        run_model(3'd5, 8'hA5);
        @(negedge clk);
        rst = 1'b1; load_r = 1'b1; op_r = 3'd0; tmp_r = 8'h33;
        @(negedge clk);
        rst = 1'b0; load_r = 1'b0;
        check("R1", "mid reset acc", acc_o, 8'h00);
        check("R1", "mid reset flags", flags_o, 8'h02);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule